// File: doc/BRIEF.md
# Auto-Incrementing Indirect Register Port

This block gives a host narrow access to a bank of 32 byte-wide internal registers through only two visible locations: a pointer register and a data window. The host first writes the pointer register with a 5-bit register index plus control flags. It then reads or writes the data window, and each of those accesses reaches the internal register that the index selects.

When the step flag in the pointer is set, every data-window access moves the index forward by one after it completes. This lets a host stream a whole message into consecutive registers, or read one back, without rewriting the pointer between bytes. If a step would carry the index past the last register, the index returns to zero and the step flag turns itself off. A burst therefore cannot silently wrap over the bottom of the bank.

The internal bank is modelled as a plain array of flip-flops. Reads are combinational from the currently selected location. All updates take effect on the rising clock edge.

Top module: `irp_indirect_port`

## Requirements
- R1: After reset the pointer register reads 0x00 and every register of the bank reads 0x00.
- R2: A write with `host_sel`=0 stores all 8 bits of `host_wdata` in the pointer register. With `host_sel`=0, `host_rdata` returns the pointer: index in bits 4:0, step flag in bit 5, and the two spare flag bits 7:6 exactly as written.
- R3: A write with `host_sel`=1 stores `host_wdata` in the bank register at the current index. With the step flag clear, the pointer is left unchanged.
- R4: With `host_sel`=1, `host_rdata` returns the bank register at the current index. With the step flag clear, a read leaves the pointer unchanged.
- R5: With the step flag set, each data-window write advances the index by one on the following clock edge.
- R6: With the step flag set, each data-window read advances the index by one on the following clock edge.
- R7: When the index is 31 and the step flag is set, a data-window access sets the index to 0 and clears the step flag. Bits 7:6 of the pointer are kept.
- R8: A data-window access that strobes read and write in the same cycle does three things. It returns the register's old content, stores the new byte, and advances the index by exactly one when the step flag is set.
- R9: Accesses to the pointer register never change any bank register.
- R10: Writing 0x2A to the pointer selects index 10 with stepping on, so N following data writes fill registers 10 to 10+N-1 in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | 0 selects the pointer register, 1 selects the data window |
| host_wr | input | 1 | Write strobe, one access per cycle it is high |
| host_rd | input | 1 | Read strobe, one access per cycle it is high |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for the selected location, combinational |

## Verification
Several behaviours are checked by the embedded properties on every cycle:
- the one-step advance with the step flag set;
- the held index with the step flag clear;
- the wrap to zero that clears the flag;
- the pointer load;
- the bank store at the addressed location.

Other behaviours show up only in the bench's scenarios, which compare against a reference model. These are: that pointer accesses leave the bank alone, that combined read-and-write returns the old byte, that the reset contents are zero, and the streamed fill starting at index 10.

// File: rtl/irp_pkg.sv
package irp_pkg;

   // Which of the two host-visible locations an access targets
   typedef enum logic {
      SEL_POINTER = 1'b0,
      SEL_WINDOW  = 1'b1
   } irp_sel_e;

   // Combined decode of one host cycle
   typedef struct packed {
      logic ptr_wr;
      logic win_wr;
      logic win_acc;
   } irp_decode_t;

endpackage

// File: rtl/irp_pointer.sv
module irp_pointer #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter int STEP_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_wr,
   input  logic [DATA_W-1:0] ptr_wdata,
   input  logic              win_acc,
   output logic [DATA_W-1:0] ptr_q,
   output logic [IDX_W-1:0]  idx
);
   localparam int                TOP_IDX = (1 << IDX_W) - 1;
   localparam logic [IDX_W-1:0]  IDX_TOP = IDX_W'(TOP_IDX);
   localparam logic [IDX_W-1:0]  IDX_ONE = IDX_W'(1);

   generate
      if (STEP_BIT < IDX_W || STEP_BIT >= DATA_W) begin : g_bad_step
         $error("irp_pointer: STEP_BIT must sit above the index field and inside the byte");
      end
   endgenerate

   logic              step_on;
   logic [DATA_W-1:0] ptr_d;

   assign idx     = ptr_q[IDX_W-1:0];
   assign step_on = ptr_q[STEP_BIT];

   always_comb begin
      ptr_d = ptr_q;
      if (ptr_wr) begin
         ptr_d = ptr_wdata;
      end else if (win_acc && step_on) begin
         if (idx == IDX_TOP) begin
            ptr_d[IDX_W-1:0] = '0;
            ptr_d[STEP_BIT]  = 1'b0;
         end else begin
            ptr_d[IDX_W-1:0] = idx + IDX_ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else        ptr_q <= ptr_d;
   end

   // R2: pointer load takes the written byte
   a_r2_pointer_load: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_wr |=> ptr_q == $past(ptr_wdata));

   // R5 / R6: one step per access below the top index
   a_r5_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && !ptr_wr && step_on && idx != IDX_TOP)
         |=> (idx == $past(idx) + IDX_ONE) && step_on);

   // R3 / R4: no movement while stepping is off
   a_r3_r4_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && !ptr_wr && !step_on) |=> $stable(ptr_q));

   // R7: running off the top wraps to zero and turns stepping off
   a_r7_wrap_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (win_acc && !ptr_wr && step_on && idx == IDX_TOP)
         |=> (idx == '0) && !step_on);

endmodule

// File: rtl/irp_bank.sv
module irp_bank #(
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_depth
         $error("irp_bank: IDX_W out of supported range");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_noclear
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[addr];

   // R3: a store lands at the location that was addressed
   a_r3_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr)] == $past(wdata));

endmodule

// File: rtl/irp_indirect_port.sv
module irp_indirect_port #(
   parameter int DATA_W         = 8,
   parameter int IDX_W          = 5,
   parameter int STEP_BIT       = 5,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata
);
   import irp_pkg::*;

   irp_decode_t       dec;
   logic [DATA_W-1:0] ptr_q;
   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] bank_rdata;

   always_comb begin
      dec.ptr_wr  = (irp_sel_e'(host_sel) == SEL_POINTER) && host_wr;
      dec.win_wr  = (irp_sel_e'(host_sel) == SEL_WINDOW)  && host_wr;
      dec.win_acc = (irp_sel_e'(host_sel) == SEL_WINDOW)  && (host_wr || host_rd);
   end

   irp_pointer #(
      .DATA_W  (DATA_W),
      .IDX_W   (IDX_W),
      .STEP_BIT(STEP_BIT)
   ) u_pointer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ptr_wr   (dec.ptr_wr),
      .ptr_wdata(host_wdata),
      .win_acc  (dec.win_acc),
      .ptr_q    (ptr_q),
      .idx      (idx)
   );

   irp_bank #(
      .DATA_W        (DATA_W),
      .IDX_W         (IDX_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (dec.win_wr),
      .addr (idx),
      .wdata(host_wdata),
      .rdata(bank_rdata)
   );

   assign host_rdata = (irp_sel_e'(host_sel) == SEL_WINDOW) ? bank_rdata : ptr_q;

   // R8: a combined strobe is still a single step
   a_r8_one_step_combined: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && host_rd && ptr_q[STEP_BIT] && idx != '1)
         |=> idx == $past(idx) + IDX_W'(1));

endmodule

// File: tb/irp_indirect_port_test.sv
module irp_indirect_port_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_sel = 1'b0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] m_ptr;
   logic [7:0] m_mem [32];

   always #5 clk = ~clk;

   irp_indirect_port uut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   function automatic logic [7:0] stepped(input logic [7:0] p);
      logic [7:0] n = p;
      if (p[5]) begin
         if (p[4:0] == 5'd31) begin
            n[4:0] = 5'd0;
            n[5]   = 1'b0;
         end else begin
            n[4:0] = p[4:0] + 5'd1;
         end
      end
      return n;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // one host cycle; returns read data sampled during the strobe
   task automatic cyc(input logic sel, input logic wr, input logic rd,
                      input logic [7:0] wd, output logic [7:0] rv);
      @(negedge clk);
      host_sel = sel; host_wr = wr; host_rd = rd; host_wdata = wd;
      #1 rv = host_rdata;
      @(posedge clk);
      #1;
      if (!sel && wr) m_ptr = wd;
      else if (sel && (wr || rd)) begin
         if (wr) m_mem[m_ptr[4:0]] = wd;
         m_ptr = stepped(m_ptr);
      end
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic ptr_write(input logic [7:0] v);
      logic [7:0] rv;
      cyc(1'b0, 1'b1, 1'b0, v, rv);
   endtask

   task automatic ptr_check(input string req);
      logic [7:0] rv;
      cyc(1'b0, 1'b0, 1'b1, 8'h00, rv);
      check(req, rv, m_ptr);
   endtask

   task automatic win_write(input logic [7:0] v);
      logic [7:0] rv;
      cyc(1'b1, 1'b1, 1'b0, v, rv);
   endtask

   task automatic win_read(input string req);
      logic [7:0] rv;
      logic [7:0] exp;
      exp = m_mem[m_ptr[4:0]];
      cyc(1'b1, 1'b0, 1'b1, 8'h00, rv);
      check(req, rv, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=00 expected=01");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] rv;
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      m_ptr = '0;
      for (int i = 0; i < 32; i++) m_mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      ptr_check("R1 pointer reset");
      ptr_write(8'h20);
      for (int i = 0; i < 32; i++) win_read("R1 R6 bank reset");
      // R7: wrapped after 32 reads, flag cleared
      ptr_check("R7 wrap after reads");

      // R10: stream fill from index 10
      ptr_write(8'h2A);
      for (int i = 0; i < 6; i++) win_write(8'hA0 + 8'(i));
      ptr_check("R5 R10 index after fill");
      check("R10 pointer value", m_ptr, 8'h30);
      ptr_write(8'h2A);
      for (int i = 0; i < 6; i++) begin
         cyc(1'b1, 1'b0, 1'b1, 8'h00, rv);
         check("R10 streamed byte", rv, 8'hA0 + 8'(i));
      end

      // R3 R4: stepping off keeps index
      ptr_write(8'h0B);
      win_read("R4 read no step");
      ptr_check("R4 index held");
      win_write(8'h5C);
      ptr_check("R3 index held");
      win_read("R3 stored value");

      // R7: spare flags survive wrap via write
      ptr_write(8'hFF);
      ptr_check("R2 full byte readback");
      win_write(8'h77);
      ptr_check("R7 wrap on write");
      check("R7 wrap value", m_ptr, 8'hC0);

      // R8: combined strobe
      ptr_write(8'h23);
      m_mem[3] = m_mem[3];
      begin
         logic [7:0] old;
         old = m_mem[3];
         cyc(1'b1, 1'b1, 1'b1, 8'h55, rv);
         check("R8 old data returned", rv, old);
      end
      ptr_check("R8 single step");
      ptr_write(8'h03);
      win_read("R8 new data stored");

      // R9: pointer traffic leaves bank alone
      for (int i = 0; i < 8; i++) ptr_write(8'($urandom));
      ptr_write(8'h20);
      for (int i = 0; i < 32; i++) win_read("R9 bank untouched");

      // random mix
      for (int n = 0; n < 600; n++) begin
         int unsigned op;
         op = $urandom % 8;
         case (op)
            0: ptr_write(8'($urandom));
            1: ptr_check("R2 random pointer");
            2, 3: win_write(8'($urandom));
            4, 5: win_read("R4 R6 random read");
            6: begin
               logic [7:0] old;
               old = m_mem[m_ptr[4:0]];
               cyc(1'b1, 1'b1, 1'b1, 8'($urandom), rv);
               check("R8 random combined", rv, old);
            end
            default: ptr_write({2'($urandom), 1'b1, 5'($urandom)});
         endcase
      end
      ptr_check("R5 final pointer");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule